// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the register file and control logic of one bus-master DMA channel that sits next to a SCSI protocol core. Software uses a simple word-indexed read/write port to program a start count, a start address and a start descriptor address. It then writes a command word. A start command copies the start values into working copies and raises the DMA enable toward the core. An abort command sends a one-cycle cancel request. An idle command drops the enable.

While data moves, the transfer side presents a grant strobe with a byte length and a direction. The block clamps each length to the remaining working count, counts the working count down and moves the working address up. A grant whose direction disagrees with the programmed direction is dropped. A command-complete pulse from the core empties the working count and sets the done flag. The status word mirrors the core's interrupt line. Its sticky flags are cleared in one of two ways, picked by a mode input: by writing ones to them, or by reading the status word.

Descriptor-list mode and the blast command are accepted and stored, but they have no effect.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, command reads 0, working count reads 0, working address reads 0xFFFFFFFF, working descriptor address reads 0xFFFFFFFD, status reads 0, and the enable, abort and load outputs are low.
- R2: Indices 0 (command), 1 (start count), 2 (start address) and 6 (start descriptor address) read back what was written. Writes to index 3 (working count), 4 (working address) and 7 (working descriptor address) leave those registers unchanged.
- R3: Writing the command with bits [1:0] = 3 (start) does the following. It copies start count into working count, start address into working address and start descriptor address into working descriptor address. It clears status bits 0 to 5 and sets the enable. It gives a load pulse that is exactly one cycle long.
- R4: Command bits [1:0] = 0 (idle) clear the enable. Bits [1:0] = 1 (blast) change neither the enable nor the counters.
- R5: Command bits [1:0] = 2 (abort) give a cancel request exactly one cycle long and leave the enable as it was.
- R6: The direction output equals command bit 7, where 1 means device to memory.
- R7: A granted transfer whose direction matches command bit 7 moves min(length, working count) bytes. The working count drops by that amount and the working address rises by it. The start address does not change.
- R8: A granted transfer whose direction differs from command bit 7 leaves the working count and working address unchanged.
- R9: A command-complete pulse sets the working count to 0 and sets status bit 3 (done).
- R10: When the mode input is 0, a status write clears each of status bits 1 (error), 2 (abort) and 3 (done) whose written bit is 1, and leaves the others.
- R11: When the mode input is 1, status writes are ignored. A status read returns the current bits and then clears bits 1 to 3.
- R12: Status bit 4 reads as 1 while the core interrupt input is high. It is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx, combinational |
| stat_rc_mode | input | 1 | 1 = clear-on-read status, 0 = write-one-to-clear |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| xfer_grant | input | 1 | Transfer granted this cycle |
| xfer_to_mem | input | 1 | Direction of the granted transfer, 1 = device to memory |
| xfer_len | input | 16 | Requested byte length |
| cmd_done | input | 1 | Command-complete pulse from the core |
| core_dma_en | output | 1 | DMA enable toward the core |
| dma_dir | output | 1 | Programmed transfer direction |
| abort_req | output | 1 | One-cycle cancel request |
| load_pulse | output | 1 | One-cycle pulse after a start snapshot |

## Verification
On every cycle, the assertions check the following. The load and abort pulses agree with the enable state. The working count never rises except when a start snapshot is taken. Mismatched-direction grants leave the counters frozen. Status writes change nothing in clear-on-read mode, and a complete pulse always leaves the done flag set. Only the bench scenarios can show that values reach the right registers and indices. These include the exact snapshot values, the clamped arithmetic, the read-then-clear ordering of the status word, and the unstored interrupt mirror.

// File: rtl/dma_chan_pkg.sv
// Shared constants for the DMA channel register block.
// Assumes 32-bit registers and an 8-entry word index space.
package dma_chan_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;

    // Register word indices
    localparam logic [IDX_W-1:0] IX_CMD   = 3'd0;
    localparam logic [IDX_W-1:0] IX_SCNT  = 3'd1;
    localparam logic [IDX_W-1:0] IX_SADR  = 3'd2;
    localparam logic [IDX_W-1:0] IX_WCNT  = 3'd3;
    localparam logic [IDX_W-1:0] IX_WADR  = 3'd4;
    localparam logic [IDX_W-1:0] IX_STAT  = 3'd5;
    localparam logic [IDX_W-1:0] IX_SDSC  = 3'd6;
    localparam logic [IDX_W-1:0] IX_WDSC  = 3'd7;

    // Command field positions
    localparam int CMD_DIR_BIT = 7;

    // Status bit positions
    localparam int ST_ERR  = 1;
    localparam int ST_ABT  = 2;
    localparam int ST_DONE = 3;
    localparam int ST_IRQ  = 4;
    localparam int ST_W    = 6;

    // Reset values of working pointers
    localparam logic [DATA_W-1:0] WADR_RST = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] WDSC_RST = 32'hFFFF_FFFD;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_BLAST = 2'd1,
        ACT_ABORT = 2'd2,
        ACT_START = 2'd3
    } dma_act_e;
endpackage

// File: rtl/dma_cmd_ctrl.sv
// Command register and action decoder.
// Stores the command word, decodes bits [1:0] into an action, holds the
// DMA enable and produces one-cycle abort and load pulses.
// Assumes at most one register write per cycle.
module dma_cmd_ctrl
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_q,
    output logic              start_req,
    output logic              dma_en,
    output logic              abort_pulse,
    output logic              start_pulse
);
    dma_act_e act;

    // Decode the action carried by the written word
    always_comb begin
        act       = dma_act_e'(wdata[1:0]);
        start_req = cmd_wr && (act == ACT_START);
    end

    // Command storage, enable and action pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            dma_en      <= 1'b0;
            abort_pulse <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            abort_pulse <= 1'b0;
            start_pulse <= 1'b0;
            if (cmd_wr) begin
                cmd_q <= wdata;
                unique case (act)
                    ACT_IDLE:  dma_en <= 1'b0;
                    ACT_BLAST: ;
                    ACT_ABORT: abort_pulse <= 1'b1;
                    ACT_START: begin
                        dma_en      <= 1'b1;
                        start_pulse <= 1'b1;
                    end
                endcase
            end
        end
    end

    assert_load_with_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> dma_en);
    assert_abort_keeps_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_pulse && !start_pulse) |-> (dma_en == $past(dma_en)));
    assert_pulses_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_pulse && start_pulse));
endmodule

// File: rtl/dma_xfer_track.sv
// Start and working pointer registers.
// Holds the software-set start values and the working count, address and
// descriptor address. Snapshots on start, counts on matching grants and
// empties the count on command completion.
// Assumes the start request and a transfer grant may coincide; start wins.
module dma_xfer_track
    import dma_chan_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_scnt,
    input  logic              wr_sadr,
    input  logic              wr_sdsc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start_req,
    input  logic              cmd_dir,
    input  logic              xfer_grant,
    input  logic              xfer_to_mem,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              cmd_done,
    output logic [DATA_W-1:0] scnt_q,
    output logic [DATA_W-1:0] sadr_q,
    output logic [DATA_W-1:0] sdsc_q,
    output logic [DATA_W-1:0] wcnt_q,
    output logic [DATA_W-1:0] wadr_q,
    output logic [DATA_W-1:0] wdsc_q
);
    localparam int PAD_W = DATA_W - LEN_W;

    logic              take_ok;
    logic [DATA_W-1:0] len_ext;
    logic [DATA_W-1:0] take;

    // Accept matching grants and clamp the length to the remaining count
    always_comb begin
        take_ok = xfer_grant && (xfer_to_mem == cmd_dir);
        len_ext = {{PAD_W{1'b0}}, xfer_len};
        take    = (len_ext > wcnt_q) ? wcnt_q : len_ext;
    end

    // Start registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scnt_q <= '0;
            sadr_q <= '0;
            sdsc_q <= '0;
        end else begin
            if (wr_scnt) scnt_q <= wdata;
            if (wr_sadr) sadr_q <= wdata;
            if (wr_sdsc) sdsc_q <= wdata;
        end
    end

    // Working registers: snapshot, completion and transfer accounting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            wadr_q <= WADR_RST;
            wdsc_q <= WDSC_RST;
        end else if (start_req) begin
            wcnt_q <= scnt_q;
            wadr_q <= sadr_q;
            wdsc_q <= sdsc_q;
        end else begin
            if (cmd_done)     wcnt_q <= '0;
            else if (take_ok) wcnt_q <= wcnt_q - take;
            if (take_ok)      wadr_q <= wadr_q + take;
        end
    end

    assert_count_never_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_req |=> (wcnt_q <= $past(wcnt_q)));
    assert_mismatch_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_grant && (xfer_to_mem != cmd_dir) && !start_req && !cmd_done)
        |=> ($stable(wcnt_q) && $stable(wadr_q)));
    assert_done_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !start_req) |=> (wcnt_q == '0));
endmodule

// File: rtl/dma_status_reg.sv
// Sticky status flags.
// Clears flags on start, by write-one-to-clear or by clear-on-read
// depending on the mode input, and sets done on command completion.
// Assumes completion has priority over any clear in the same cycle.
module dma_status_reg
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic              stat_rd,
    input  logic [3:1]        wbits,
    input  logic              rc_mode,
    input  logic              start_req,
    input  logic              cmd_done,
    output logic [ST_W-1:0]   stat_q
);
    logic [ST_W-1:0] nxt;

    // Next-state of the flags
    always_comb begin
        nxt = stat_q;
        if (start_req) begin
            nxt = '0;
        end else if (!rc_mode && stat_wr) begin
            nxt[ST_DONE:ST_ERR] = stat_q[ST_DONE:ST_ERR] & ~wbits;
        end else if (rc_mode && stat_rd) begin
            nxt[ST_DONE:ST_ERR] = '0;
        end
        if (cmd_done) nxt[ST_DONE] = 1'b1;
    end

    // Flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= nxt;
    end

    assert_done_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> stat_q[ST_DONE]);
    assert_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_mode && stat_wr && !stat_rd && !start_req && !cmd_done) |=> $stable(stat_q));
    assert_irq_not_stored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q[ST_IRQ]);
endmodule

// File: rtl/dma_chan_regs.sv
// DMA channel register block top.
// Decodes the word register port, reads back the eight registers and ties
// the command, pointer and status sub-blocks together.
// Assumes reg_wr and reg_rd are not asserted together.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              stat_rc_mode,
    input  logic              core_irq,
    input  logic              xfer_grant,
    input  logic              xfer_to_mem,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              cmd_done,
    output logic              core_dma_en,
    output logic              dma_dir,
    output logic              abort_req,
    output logic              load_pulse
);
    logic [DATA_W-1:0] cmd_q, scnt_q, sadr_q, sdsc_q, wcnt_q, wadr_q, wdsc_q;
    logic [ST_W-1:0]   stat_q;
    logic              start_req;
    logic              wr_cmd, wr_scnt, wr_sadr, wr_sdsc, wr_stat, rd_stat;

    // Per-index write and read strobes
    always_comb begin
        wr_cmd  = reg_wr && (reg_idx == IX_CMD);
        wr_scnt = reg_wr && (reg_idx == IX_SCNT);
        wr_sadr = reg_wr && (reg_idx == IX_SADR);
        wr_sdsc = reg_wr && (reg_idx == IX_SDSC);
        wr_stat = reg_wr && (reg_idx == IX_STAT);
        rd_stat = reg_rd && (reg_idx == IX_STAT);
    end

    dma_cmd_ctrl u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (wr_cmd),
        .wdata       (reg_wdata),
        .cmd_q       (cmd_q),
        .start_req   (start_req),
        .dma_en      (core_dma_en),
        .abort_pulse (abort_req),
        .start_pulse (load_pulse)
    );

    dma_xfer_track #(.LEN_W(LEN_W)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_scnt     (wr_scnt),
        .wr_sadr     (wr_sadr),
        .wr_sdsc     (wr_sdsc),
        .wdata       (reg_wdata),
        .start_req   (start_req),
        .cmd_dir     (cmd_q[CMD_DIR_BIT]),
        .xfer_grant  (xfer_grant),
        .xfer_to_mem (xfer_to_mem),
        .xfer_len    (xfer_len),
        .cmd_done    (cmd_done),
        .scnt_q      (scnt_q),
        .sadr_q      (sadr_q),
        .sdsc_q      (sdsc_q),
        .wcnt_q      (wcnt_q),
        .wadr_q      (wadr_q),
        .wdsc_q      (wdsc_q)
    );

    dma_status_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_wr   (wr_stat),
        .stat_rd   (rd_stat),
        .wbits     (reg_wdata[3:1]),
        .rc_mode   (stat_rc_mode),
        .start_req (start_req),
        .cmd_done  (cmd_done),
        .stat_q    (stat_q)
    );

    assign dma_dir = cmd_q[CMD_DIR_BIT];

    // Read-back multiplexer with the interrupt mirror on the status word
    always_comb begin
        unique case (reg_idx)
            IX_CMD:  reg_rdata = cmd_q;
            IX_SCNT: reg_rdata = scnt_q;
            IX_SADR: reg_rdata = sadr_q;
            IX_WCNT: reg_rdata = wcnt_q;
            IX_WADR: reg_rdata = wadr_q;
            IX_STAT: begin
                reg_rdata = {{(DATA_W-ST_W){1'b0}}, stat_q};
                reg_rdata[ST_IRQ] = stat_q[ST_IRQ] | core_irq;
            end
            IX_SDSC: reg_rdata = sdsc_q;
            IX_WDSC: reg_rdata = wdsc_q;
        endcase
    end

    assert_dir_tracks_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> (dma_dir == $past(reg_wdata[CMD_DIR_BIT])));
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        stat_rc_mode = 1'b0, core_irq = 1'b0;
    logic        xfer_grant = 1'b0, xfer_to_mem = 1'b0;
    logic [15:0] xfer_len = '0;
    logic        cmd_done = 1'b0;
    logic        core_dma_en, dma_dir, abort_req, load_pulse;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_chan_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stat_rc_mode(stat_rc_mode), .core_irq(core_irq),
        .xfer_grant(xfer_grant), .xfer_to_mem(xfer_to_mem), .xfer_len(xfer_len),
        .cmd_done(cmd_done), .core_dma_en(core_dma_en), .dma_dir(dma_dir),
        .abort_req(abort_req), .load_pulse(load_pulse)
    );

    typedef struct packed {
        logic        is_wr;
        logic [2:0]  idx;
        logic [31:0] val;
    } vec_t;

    // Table: writes, then reads with expected value (R2 readback/ignore, R3 snapshot)
    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{1'b1, 3'd1, 32'h0000_0040},
        '{1'b1, 3'd2, 32'h1000_0000},
        '{1'b1, 3'd6, 32'hABCD_0000},
        '{1'b0, 3'd1, 32'h0000_0040},
        '{1'b0, 3'd2, 32'h1000_0000},
        '{1'b0, 3'd6, 32'hABCD_0000},
        '{1'b1, 3'd3, 32'h0000_1234},
        '{1'b0, 3'd3, 32'h0000_0000},
        '{1'b1, 3'd4, 32'h0000_0005},
        '{1'b0, 3'd4, 32'hFFFF_FFFF},
        '{1'b1, 3'd7, 32'h0000_0000},
        '{1'b0, 3'd7, 32'hFFFF_FFFD},
        '{1'b1, 3'd0, 32'h0000_0083},
        '{1'b0, 3'd3, 32'h0000_0040},
        '{1'b0, 3'd4, 32'h1000_0000},
        '{1'b0, 3'd7, 32'hABCD_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] v);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = v;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        reg_rd = 1'b1; reg_idx = idx;
        #1 v = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic xfer(input logic to_mem, input logic [15:0] len);
        xfer_grant = 1'b1; xfer_to_mem = to_mem; xfer_len = len;
        @(posedge clk); @(negedge clk);
        xfer_grant = 1'b0;
    endtask

    task automatic done_pulse();
        cmd_done = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 cmd", v, 32'h0);
        rd(3'd3, v); check("R1 wcnt", v, 32'h0);
        rd(3'd4, v); check("R1 wadr", v, 32'hFFFF_FFFF);
        rd(3'd7, v); check("R1 wdsc", v, 32'hFFFF_FFFD);
        rd(3'd5, v); check("R1 stat", v, 32'h0);
        check("R1 outputs", {28'h0, core_dma_en, dma_dir, abort_req, load_pulse}, 32'h0);

        // Table walk (R2, R3)
        for (int i = 0; i < NV; i++) begin
            if (VT[i].is_wr) begin
                wr(VT[i].idx, VT[i].val);
                if (VT[i].idx == 3'd0) begin
                    check("R3 load pulse high", {31'h0, load_pulse}, 32'h1);
                    @(negedge clk);
                    check("R3 load pulse one cycle", {31'h0, load_pulse}, 32'h0);
                end
            end else begin
                rd(VT[i].idx, v);
                check((i < 12) ? "R2 table" : "R3 table", v, VT[i].val);
            end
        end
        check("R3 enable", {31'h0, core_dma_en}, 32'h1);
        check("R6 direction", {31'h0, dma_dir}, 32'h1);
        rd(3'd0, v); check("R2 cmd readback", v, 32'h83);

        // R7 matching transfers with clamp
        xfer(1'b1, 16'h0010);
        rd(3'd3, v); check("R7 wcnt", v, 32'h30);
        rd(3'd4, v); check("R7 wadr", v, 32'h1000_0010);
        xfer(1'b1, 16'h0100);
        rd(3'd3, v); check("R7 clamp wcnt", v, 32'h0);
        rd(3'd4, v); check("R7 clamp wadr", v, 32'h1000_0040);
        rd(3'd2, v); check("R7 start addr kept", v, 32'h1000_0000);

        // R8 mismatched direction
        wr(3'd0, 32'h83);
        xfer(1'b0, 16'h0004);
        rd(3'd3, v); check("R8 wcnt", v, 32'h40);
        rd(3'd4, v); check("R8 wadr", v, 32'h1000_0000);

        // R4 blast then idle
        wr(3'd0, 32'h81);
        check("R4 blast keeps en", {31'h0, core_dma_en}, 32'h1);
        rd(3'd3, v); check("R4 blast keeps count", v, 32'h40);
        wr(3'd0, 32'h80);
        check("R4 idle drops en", {31'h0, core_dma_en}, 32'h0);

        // R5 abort pulse
        wr(3'd0, 32'h02);
        check("R5 abort high", {31'h0, abort_req}, 32'h1);
        check("R5 en unchanged", {31'h0, core_dma_en}, 32'h0);
        check("R6 dir cleared", {31'h0, dma_dir}, 32'h0);
        @(negedge clk);
        check("R5 abort one cycle", {31'h0, abort_req}, 32'h0);

        // R9 completion
        done_pulse();
        rd(3'd3, v); check("R9 wcnt zero", v, 32'h0);
        rd(3'd5, v); check("R9 done set", v, 32'h08);

        // R12 interrupt mirror
        core_irq = 1'b1;
        rd(3'd5, v); check("R12 irq shown", v, 32'h18);
        core_irq = 1'b0;
        rd(3'd5, v); check("R12 irq not stored", v, 32'h08);

        // R10 write-one-to-clear
        wr(3'd5, 32'h06);
        rd(3'd5, v); check("R10 other bits kept", v, 32'h08);
        wr(3'd5, 32'h08);
        rd(3'd5, v); check("R10 done cleared", v, 32'h00);

        // R11 clear-on-read
        done_pulse();
        stat_rc_mode = 1'b1;
        wr(3'd5, 32'h0E);
        rd(3'd5, v); check("R11 write ignored", v, 32'h08);
        rd(3'd5, v); check("R11 cleared by read", v, 32'h00);
        stat_rc_mode = 1'b0;

        // R3 start clears status
        done_pulse();
        wr(3'd0, 32'h03);
        rd(3'd5, v); check("R3 status cleared", v, 32'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule